// File: doc/BRIEF.md
# Triggered Multi-Slot Event Capture Gate

This block sits in one sector's readout path, after the hit/cluster stage and before the link to the data acquisition system. Cluster words come in as a stream, one per clock at most. The block holds several independent capture slots. A trigger claims one idle slot and arms it. After a programmable delay, the slot opens a capture window that lasts exactly one frame of clocks. The delay lets the window start at the raster position of the event's first pixel. Every cluster word that arrives while a slot's window is open goes into that slot's private store. Several slots can have open windows at once, so triggers spaced closer than one frame readout are all captured.

A slot can be drained only after its window has closed. Closed events leave on a single output stream in the order their triggers were accepted. Each event goes out as a start marker, then its stored words in arrival order, then an end marker. Both markers carry the event's sequence number. If a trigger arrives while every slot is in use, it is refused and counted, and a busy flag shows that no slot is free.

Top module: `trig_event_gate`

## Requirements
- R1: After reset, `ev_valid_o` is low, `busy_o` is low, `rej_count_o` is zero and all slots are idle.
- R2: An accepted trigger claims the idle slot with the lowest index. Accepted triggers receive sequence numbers 0, 1, 2, ... (modulo 2^SEQ_W). Refused triggers do not use up a number.
- R3: For a trigger sampled at clock edge k with latched offset D, the event holds exactly the words with `pix_valid_i` high at edges k+1+D through k+D+FRAME_LEN. The window counter wraps modulo FRAME_LEN.
- R4: Slots capture independently. A word that falls inside the open windows of several slots is stored in each of them.
- R5: No word of an event appears on the output before the clock edge that closes its window.
- R6: Events are emitted in trigger order, one word per clock with no gaps. The start marker has `ev_kind_o`=2'b01 and data equal to the sequence number, zero-extended. Data words have kind 2'b00 and come out in arrival order. The end marker has kind 2'b10 and data equal to the sequence number. Kind 2'b11 is never emitted.
- R7: `busy_o` is high exactly when no slot is idle. A trigger sampled while busy claims no slot and increments `rej_count_o` by one (wrapping). Otherwise the count holds.
- R8: `cfg_wr_i` loads `cfg_offset_i` into the offset register at the clock edge. A trigger at that same edge uses the previous offset. The offset is latched into the slot when the trigger is accepted.
- R9: A slot stores at most DEPTH words. Further words in its window are dropped, and the first DEPTH are kept.
- R10: A slot becomes idle again at the edge where its end marker is emitted. It can be re-claimed by a trigger sampled on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger; each clock it is high counts as one trigger |
| cfg_wr_i | input | 1 | Load strobe for the offset register |
| cfg_offset_i | input | OFF_W | Delay from trigger to window start, in clocks |
| pix_valid_i | input | 1 | Cluster word present |
| pix_data_i | input | DATA_W | Cluster word |
| busy_o | output | 1 | No idle slot |
| rej_count_o | output | CNT_W | Count of refused triggers |
| ev_valid_o | output | 1 | Output word valid |
| ev_kind_o | output | 2 | Word kind: 00 data, 01 start, 10 end |
| ev_data_o | output | DATA_W | Output word or sequence number |

## Verification
The assertions assume the downstream link accepts a word on every clock in which `ev_valid_o` is high. They also assume that each high clock of `trig_i` is meant as a separate trigger. The stimulus drives every input at the falling edge and makes triggers single-clock pulses. It keeps offsets below one frame and chooses trigger spacing so that some trigger patterns fill every slot and others leave slots free. A behavioural model of slots, trigger-order queue and drain sequence is compared against the output stream, busy flag and refusal count on every clock.

// File: rtl/evg_pkg.sv
package evg_pkg;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_WAIT = 2'd1,
    SL_CAPT = 2'd2,
    SL_DONE = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_START = 2'd1,
    DR_DATA  = 2'd2,
    DR_END   = 2'd3
  } drain_st_e;

  localparam logic [1:0] KIND_DATA  = 2'b00;
  localparam logic [1:0] KIND_START = 2'b01;
  localparam logic [1:0] KIND_END   = 2'b10;

endpackage

// File: rtl/evg_slot.sv
module evg_slot
  import evg_pkg::*;
#(
  parameter int FRAME_LEN = 204800,
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 18,
  parameter int SEQ_W     = 8,
  parameter int OFF_W     = 18,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LVL_W    = PTR_W + 1,
  localparam int WIN_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [OFF_W-1:0]  arm_off_i,
  input  logic [SEQ_W-1:0]  arm_seq_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic              pop_i,
  input  logic              release_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [DATA_W-1:0] head_o,
  output logic [SEQ_W-1:0]  seq_o
);

  slot_st_e          st_q, st_d;
  logic [OFF_W-1:0]  dly_q, dly_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [PTR_W-1:0]  wptr_q, wptr_d;
  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_en;
  logic              last_win;

  assign last_win = (win_q == WIN_W'(FRAME_LEN - 1));
  assign wr_en    = (st_q == SL_CAPT) && pix_valid_i && (lvl_q != LVL_W'(DEPTH));

  always_comb begin
    st_d   = st_q;
    dly_d  = dly_q;
    win_d  = win_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    seq_d  = seq_q;
    case (st_q)
      SL_IDLE: begin
        if (arm_i) begin
          seq_d  = arm_seq_i;
          wptr_d = '0;
          rptr_d = '0;
          lvl_d  = '0;
          win_d  = '0;
          if (arm_off_i == '0) begin
            st_d = SL_CAPT;
          end else begin
            st_d  = SL_WAIT;
            dly_d = arm_off_i - 1'b1;
          end
        end
      end
      SL_WAIT: begin
        if (dly_q == '0) begin
          st_d  = SL_CAPT;
          win_d = '0;
        end else begin
          dly_d = dly_q - 1'b1;
        end
      end
      SL_CAPT: begin
        if (wr_en) begin
          wptr_d = wptr_q + 1'b1;
          lvl_d  = lvl_q + 1'b1;
        end
        if (last_win) begin
          st_d  = SL_DONE;
          win_d = '0;
        end else begin
          win_d = win_q + 1'b1;
        end
      end
      default: begin
        if (pop_i) begin
          rptr_d = rptr_q + 1'b1;
        end
        if (release_i) begin
          st_d = SL_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SL_IDLE;
      dly_q  <= '0;
      win_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
      seq_q  <= '0;
    end else begin
      st_q   <= st_d;
      dly_q  <= dly_d;
      win_q  <= win_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
      seq_q  <= seq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wptr_q] <= pix_data_i;
    end
  end

  assign idle_o  = (st_q == SL_IDLE);
  assign done_o  = (st_q == SL_DONE);
  assign level_o = lvl_q;
  assign head_o  = mem[rptr_q];
  assign seq_o   = seq_q;

endmodule

// File: rtl/evg_order.sv
module evg_order #(
  parameter int N_BUF   = 5,
  localparam int IDX_W  = $clog2(N_BUF),
  localparam int CNT_W  = $clog2(N_BUF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic             nonempty_o,
  output logic [CNT_W-1:0] count_o
);

  logic [IDX_W-1:0] ent [N_BUF];
  logic [IDX_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N_BUF - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push_i) begin
      wr_d = wrap_inc(wr_q);
    end
    if (pop_i) begin
      rd_d = wrap_inc(rd_q);
    end
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      ent[wr_q] <= push_idx_i;
    end
  end

  assign head_o     = ent[rd_q];
  assign nonempty_o = (cnt_q != '0);
  assign count_o    = cnt_q;

endmodule

// File: rtl/evg_drain.sv
module evg_drain
  import evg_pkg::*;
#(
  parameter int N_BUF   = 5,
  parameter int DEPTH   = 64,
  parameter int DATA_W  = 18,
  parameter int SEQ_W   = 8,
  localparam int IDX_W  = $clog2(N_BUF),
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          q_nonempty_i,
  input  logic [IDX_W-1:0]              q_head_i,
  input  logic [N_BUF-1:0]              slot_done_i,
  input  logic [N_BUF-1:0][LVL_W-1:0]   slot_level_i,
  input  logic [N_BUF-1:0][DATA_W-1:0]  slot_head_i,
  input  logic [N_BUF-1:0][SEQ_W-1:0]   slot_seq_i,
  output logic [N_BUF-1:0]              pop_o,
  output logic [N_BUF-1:0]              release_o,
  output logic                          q_pop_o,
  output logic                          ev_valid_o,
  output logic [1:0]                    ev_kind_o,
  output logic [DATA_W-1:0]             ev_data_o
);

  drain_st_e        st_q, st_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [LVL_W-1:0] rem_q, rem_d;

  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    rem_d      = rem_q;
    pop_o      = '0;
    release_o  = '0;
    q_pop_o    = 1'b0;
    ev_valid_o = 1'b0;
    ev_kind_o  = KIND_DATA;
    ev_data_o  = '0;
    case (st_q)
      DR_IDLE: begin
        if (q_nonempty_i && slot_done_i[q_head_i]) begin
          st_d  = DR_START;
          cur_d = q_head_i;
          rem_d = slot_level_i[q_head_i];
        end
      end
      DR_START: begin
        ev_valid_o = 1'b1;
        ev_kind_o  = KIND_START;
        ev_data_o  = DATA_W'(slot_seq_i[cur_q]);
        st_d       = (rem_q == '0) ? DR_END : DR_DATA;
      end
      DR_DATA: begin
        ev_valid_o   = 1'b1;
        ev_kind_o    = KIND_DATA;
        ev_data_o    = slot_head_i[cur_q];
        pop_o[cur_q] = 1'b1;
        rem_d        = rem_q - 1'b1;
        if (rem_q == LVL_W'(1)) begin
          st_d = DR_END;
        end
      end
      default: begin
        ev_valid_o       = 1'b1;
        ev_kind_o        = KIND_END;
        ev_data_o        = DATA_W'(slot_seq_i[cur_q]);
        release_o[cur_q] = 1'b1;
        q_pop_o          = 1'b1;
        st_d             = DR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DR_IDLE;
      cur_q <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/trig_event_gate.sv
module trig_event_gate
  import evg_pkg::*;
#(
  parameter int N_BUF     = 5,
  parameter int FRAME_LEN = 204800,
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 18,
  parameter int SEQ_W     = 8,
  parameter int CNT_W     = 16,
  localparam int OFF_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              cfg_wr_i,
  input  logic [OFF_W-1:0]  cfg_offset_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  rej_count_o,
  output logic              ev_valid_o,
  output logic [1:0]        ev_kind_o,
  output logic [DATA_W-1:0] ev_data_o
);

  localparam int IDX_W  = $clog2(N_BUF);
  localparam int LVL_W  = $clog2(DEPTH) + 1;
  localparam int OCNT_W = $clog2(N_BUF + 1);

  logic [OFF_W-1:0] off_q, off_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [CNT_W-1:0] rej_q, rej_d;

  logic [N_BUF-1:0]             slot_idle, slot_done, slot_arm, slot_pop, slot_rel;
  logic [N_BUF-1:0][LVL_W-1:0]  slot_level;
  logic [N_BUF-1:0][DATA_W-1:0] slot_head;
  logic [N_BUF-1:0][SEQ_W-1:0]  slot_seq;
  logic [IDX_W-1:0]             pick;
  logic                         any_idle, accept;
  logic [IDX_W-1:0]             ord_head;
  logic                         ord_nonempty, ord_pop;
  logic [OCNT_W-1:0]            ord_count;

  always_comb begin
    pick     = '0;
    any_idle = 1'b0;
    for (int i = N_BUF - 1; i >= 0; i--) begin
      if (slot_idle[i]) begin
        pick     = IDX_W'(i);
        any_idle = 1'b1;
      end
    end
  end

  assign accept = trig_i && any_idle;
  assign busy_o = !any_idle;

  always_comb begin
    off_d = off_q;
    seq_d = seq_q;
    rej_d = rej_q;
    if (cfg_wr_i) begin
      off_d = cfg_offset_i;
    end
    if (accept) begin
      seq_d = seq_q + 1'b1;
    end
    if (trig_i && !any_idle) begin
      rej_d = rej_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      seq_q <= '0;
      rej_q <= '0;
    end else begin
      off_q <= off_d;
      seq_q <= seq_d;
      rej_q <= rej_d;
    end
  end

  assign rej_count_o = rej_q;

  for (genvar g = 0; g < N_BUF; g++) begin : g_slot
    assign slot_arm[g] = accept && (pick == IDX_W'(g));

    evg_slot #(
      .FRAME_LEN (FRAME_LEN),
      .DEPTH     (DEPTH),
      .DATA_W    (DATA_W),
      .SEQ_W     (SEQ_W),
      .OFF_W     (OFF_W)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (slot_arm[g]),
      .arm_off_i   (off_q),
      .arm_seq_i   (seq_q),
      .pix_valid_i (pix_valid_i),
      .pix_data_i  (pix_data_i),
      .pop_i       (slot_pop[g]),
      .release_i   (slot_rel[g]),
      .idle_o      (slot_idle[g]),
      .done_o      (slot_done[g]),
      .level_o     (slot_level[g]),
      .head_o      (slot_head[g]),
      .seq_o       (slot_seq[g])
    );
  end

  evg_order #(
    .N_BUF (N_BUF)
  ) u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept),
    .push_idx_i (pick),
    .pop_i      (ord_pop),
    .head_o     (ord_head),
    .nonempty_o (ord_nonempty),
    .count_o    (ord_count)
  );

  evg_drain #(
    .N_BUF  (N_BUF),
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .SEQ_W  (SEQ_W)
  ) u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_nonempty_i (ord_nonempty),
    .q_head_i     (ord_head),
    .slot_done_i  (slot_done),
    .slot_level_i (slot_level),
    .slot_head_i  (slot_head),
    .slot_seq_i   (slot_seq),
    .pop_o        (slot_pop),
    .release_o    (slot_rel),
    .q_pop_o      (ord_pop),
    .ev_valid_o   (ev_valid_o),
    .ev_kind_o    (ev_kind_o),
    .ev_data_o    (ev_data_o)
  );

endmodule

// File: rtl/evg_checker.sv
module evg_checker #(
  parameter int N_BUF  = 5,
  parameter int CNT_W  = 16,
  localparam int OCNT_W = $clog2(N_BUF + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              busy_o,
  input logic [CNT_W-1:0]  rej_count_o,
  input logic              ev_valid_o,
  input logic [1:0]        ev_kind_o,
  input logic [N_BUF-1:0]  slot_idle,
  input logic [OCNT_W-1:0] ord_count
);

  assert_kind_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> (ev_kind_o != 2'b11));

  assert_start_then_body_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_kind_o == 2'b01) |=> (ev_valid_o && ev_kind_o != 2'b01));

  assert_end_then_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_kind_o == 2'b10) |=> !(ev_valid_o && ev_kind_o != 2'b01));

  assert_queue_tracks_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ord_count) == $countones(~slot_idle)));

  assert_reject_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_o) |=> (rej_count_o == $past(rej_count_o) + 1'b1));

  assert_reject_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_i && busy_o) |=> $stable(rej_count_o));

  assert_reject_no_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_o) |=> (ord_count <= $past(ord_count)));

endmodule

bind trig_event_gate evg_checker #(
  .N_BUF (N_BUF),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_i      (trig_i),
  .busy_o      (busy_o),
  .rej_count_o (rej_count_o),
  .ev_valid_o  (ev_valid_o),
  .ev_kind_o   (ev_kind_o),
  .slot_idle   (slot_idle),
  .ord_count   (ord_count)
);

// File: tb/trig_event_gate_tb.sv
`timescale 1ns/1ps
module trig_event_gate_tb;

  localparam int N   = 5;
  localparam int FL  = 40;
  localparam int DP  = 16;
  localparam int DW  = 18;
  localparam int SW  = 8;
  localparam int CW  = 16;
  localparam int OW  = $clog2(FL);

  logic          clk;
  logic          rst_n;
  logic          trig;
  logic          cfg_wr;
  logic [OW-1:0] cfg_off;
  logic          pix_valid;
  logic [DW-1:0] pix_data;
  logic          busy;
  logic [CW-1:0] rej;
  logic          ev_valid;
  logic [1:0]    ev_kind;
  logic [DW-1:0] ev_data;

  trig_event_gate #(
    .N_BUF(N), .FRAME_LEN(FL), .DEPTH(DP), .DATA_W(DW), .SEQ_W(SW), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .cfg_wr_i(cfg_wr),
    .cfg_offset_i(cfg_off), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .busy_o(busy), .rej_count_o(rej), .ev_valid_o(ev_valid),
    .ev_kind_o(ev_kind), .ev_data_o(ev_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    errs;
  int    checks;
  bit    run;
  bit    finished;
  string cur_req;
  int    pix_per;
  int    cyc;

  // behavioural model: 0 idle, 1 waiting, 2 capturing, 3 closed
  int            mst [N];
  int            mdly [N];
  int            mwin [N];
  int            mlen [N];
  int            mseq [N];
  logic [DW-1:0] mdat [N][DP];
  int            mo[$];
  int            mdst, mcur, mdi, mnext, mrej, moff;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    pix_valid <= (pix_per != 0) && (cyc % (pix_per == 0 ? 1 : pix_per) == 0);
    pix_data  <= DW'(cyc);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mst[i] = 0; mdly[i] = 0; mwin[i] = 0; mlen[i] = 0; mseq[i] = 0;
      end
      mo.delete();
      mdst = 0; mcur = 0; mdi = 0; mnext = 0; mrej = 0; moff = 0;
    end else begin
      int so [N];
      bit any;
      int pk;
      any = 1'b0;
      pk  = 0;
      for (int i = 0; i < N; i++) so[i] = mst[i];
      for (int i = N - 1; i >= 0; i--) if (so[i] == 0) begin any = 1'b1; pk = i; end
      case (mdst)
        0: if (mo.size() > 0 && so[mo[0]] == 3) begin mcur = mo[0]; mdst = 1; mdi = 0; end
        1: mdst = (mlen[mcur] > 0) ? 2 : 3;
        2: begin mdi++; if (mdi == mlen[mcur]) mdst = 3; end
        default: begin mst[mcur] = 0; void'(mo.pop_front()); mdst = 0; end
      endcase
      for (int i = 0; i < N; i++) begin
        if (so[i] == 1) begin
          if (mdly[i] == 0) begin mst[i] = 2; mwin[i] = 0; end
          else mdly[i]--;
        end else if (so[i] == 2) begin
          if (pix_valid && mlen[i] < DP) begin mdat[i][mlen[i]] = pix_data; mlen[i]++; end
          if (mwin[i] == FL - 1) mst[i] = 3;
          else mwin[i]++;
        end
      end
      if (trig) begin
        if (any) begin
          mlen[pk] = 0;
          mseq[pk] = mnext % (1 << SW);
          mnext++;
          if (moff == 0) begin mst[pk] = 2; mwin[pk] = 0; end
          else begin mst[pk] = 1; mdly[pk] = moff - 1; end
          mo.push_back(pk);
        end else begin
          mrej++;
        end
      end
      if (cfg_wr) moff = int'(cfg_off);
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      int ev, ek, ed, eb;
      ev = 0; ek = 0; ed = 0; eb = 1;
      for (int i = 0; i < N; i++) if (mst[i] == 0) eb = 0;
      case (mdst)
        1: begin ev = 1; ek = 1; ed = mseq[mcur]; end
        2: begin ev = 1; ek = 0; ed = int'(mdat[mcur][mdi]); end
        3: begin ev = 1; ek = 2; ed = mseq[mcur]; end
        default: ev = 0;
      endcase
      chk(cur_req, "ev_valid", int'(ev_valid), ev);
      if (ev == 1) begin
        chk(cur_req, "ev_kind", int'(ev_kind), ek);
        chk(cur_req, "ev_data", int'(ev_data), ed);
      end
      chk("R7", "busy", int'(busy), eb);
      chk("R7", "rej_count", int'(rej), mrej % (1 << CW));
    end
  end

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic set_off(input int v);
    cfg_wr  = 1'b1;
    cfg_off = OW'(v);
    @(negedge clk);
    cfg_wr  = 1'b0;
  endtask

  task automatic wait_quiet();
    bit q;
    q = 1'b0;
    while (!q) begin
      @(negedge clk);
      q = (mdst == 0);
      for (int i = 0; i < N; i++) if (mst[i] != 0) q = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    errs = 0; checks = 0; run = 1'b0; finished = 1'b0;
    cur_req = "R1"; pix_per = 0; cyc = 0;
    trig = 1'b0; cfg_wr = 1'b0; cfg_off = '0;
    pix_valid = 1'b0; pix_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ev_valid after reset", int'(ev_valid), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "rej_count after reset", int'(rej), 0);
    run = 1'b1;

    // R3 R5: single event, offset zero, sparse words
    cur_req = "R3 R5";
    pix_per = 3;
    repeat (2) @(negedge clk);
    pulse_trig();
    wait_quiet();

    // R8: offset written together with a trigger uses the old value
    cur_req = "R8";
    cfg_wr = 1'b1; cfg_off = OW'(9); trig = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; trig = 1'b0;
    wait_quiet();
    pulse_trig();
    wait_quiet();
    set_off(FL - 1);
    pulse_trig();
    wait_quiet();

    // R6: long-offset event completes after a later short one but drains first
    cur_req = "R6";
    set_off(25);
    pulse_trig();
    set_off(0);
    pulse_trig();
    wait_quiet();

    // R2 R4 R7 R10: fill every slot, then refuse extra triggers
    cur_req = "R2 R4 R10";
    pix_per = 5;
    for (int k = 0; k < N; k++) begin
      pulse_trig();
      repeat (5) @(negedge clk);
    end
    cur_req = "R7";
    pulse_trig();
    pulse_trig();
    cur_req = "R10";
    while (busy) @(negedge clk);
    pulse_trig();
    wait_quiet();

    // R9: dense stream overflows a slot
    cur_req = "R9";
    pix_per = 1;
    pulse_trig();
    repeat (3) @(negedge clk);
    pulse_trig();
    wait_quiet();

    pix_per = 0;
    repeat (4) @(negedge clk);
    chk("R7", "final refusals", int'(rej), 2);
    chk("R2", "accepted trigger count", mnext, 14);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL all watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule